// File: doc/BRIEF.md
# Command Status Controller for a Byte-FIFO Command Interface

This block is the device-side status engine behind a byte-wide command FIFO. A host moves a command into the device one byte at a time. It tells the device to run the command by writing a status byte. It then drains the response byte by byte. The controller follows that life cycle and reports it through three values: a status byte, an extended status byte and a burst count. The burst count tells the host how many FIFO accesses in a row it may make. The FIFO storage and the command engine live elsewhere. The controller gives the engine a one-cycle start pulse and a one-cycle abort pulse. The engine answers with a done pulse that carries the response length.

The life cycle is a four-state machine:
- **READY**: the state after reset.
- **RECEIVE**: entered on the first command byte.
- **EXECUTE**: entered on an accepted go.
- **COMPLETE**: entered on the engine's done pulse.

The transitions are named:
- **first_byte**: READY to RECEIVE.
- **go_accept**: RECEIVE to EXECUTE. It is allowed only when no more bytes are expected.
- **exec_finish**: EXECUTE to COMPLETE.
- **discard**: COMPLETE to READY. The host writes the ready bit.

The command length is taken from bytes 2 to 5 of the command header, most significant byte first. This length decides when the device stops expecting bytes. In COMPLETE a response read pointer is driven out to the storage. The host can rewind this pointer to the first response byte with a retry write.

Top module: `cmdstat_ctrl`

## Requirements
- R1: After reset the controller is in READY. Status reads 0xC0, extended status reads 0x04, burst count reads BURST_MAX (32), the response pointer is 0 and both pulses are low.
- R2: A FIFO write in READY moves to RECEIVE. Status then reads 0x88: bit 7 valid, bit 3 expect, bit 6 clear.
- R3: Bytes 2..5 of a command (counting from 0) form a big-endian length. Expect (status bit 3) clears once the received byte count reaches the larger of that length and 6. After that, further FIFO writes are ignored. In RECEIVE the burst count is BURST_MAX until six bytes have arrived, then the smaller of BURST_MAX and the bytes still missing, and 0 once nothing is expected.
- R4: Writing status bit 5 (go) in RECEIVE with expect clear enters EXECUTE. `exec_start` is high for the one cycle after that write, and status reads 0x00 with burst 0. A go while expect is set is ignored.
- R5: `exec_done` in EXECUTE enters COMPLETE. It captures `exec_rsp_len` and sets the response pointer to 0. Status reads 0x90 if the length is non-zero, and 0x80 if it is zero.
- R6: In COMPLETE, each FIFO read advances the pointer while data remains. Status bit 4 clears when the pointer reaches the response length, and reads after that leave it unchanged. The burst count is the smaller of BURST_MAX and the bytes remaining.
- R7: Writing status bit 1 (retry) in COMPLETE returns the pointer to 0. In any other state it is ignored.
- R8: Writing extended-status bit 0 (cancel) in EXECUTE gives a one-cycle `exec_abort` pulse in the next cycle, and the state stays EXECUTE. A cancel in any other state gives no pulse.
- R9: If a cancel and `exec_done` fall in the same cycle, the done is taken: the controller enters COMPLETE and no abort pulse is issued.
- R10: Writing status bit 6 in COMPLETE discards the response and returns to READY (status 0xC0). The same write in RECEIVE or EXECUTE is ignored.
- R11: Extended-status bits 3:2 always read the FAMILY parameter (default 01, meaning the 2.0 family). All other extended bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sts_wr | input | 1 | Host write strobe for the status byte |
| sts_wdata | input | 8 | Status write data (bit 6 ready, 5 go, 1 retry) |
| stx_wr | input | 1 | Host write strobe for the extended status byte |
| stx_wdata | input | 8 | Extended status write data (bit 0 cancel) |
| fifo_wr | input | 1 | Command byte written into the FIFO |
| fifo_wdata | input | 8 | Command byte value |
| fifo_rd | input | 1 | Response byte read from the FIFO |
| exec_done | input | 1 | Engine finished, one-cycle pulse |
| exec_rsp_len | input | CNT_W | Response length valid with exec_done |
| sts_rdata | output | 8 | Status byte read value |
| stx_rdata | output | 8 | Extended status read value |
| burst_cnt | output | CNT_W | Consecutive FIFO accesses allowed |
| rsp_ptr | output | CNT_W | Index of next response byte |
| exec_start | output | 1 | One-cycle pulse: begin execution |
| exec_abort | output | 1 | One-cycle pulse: abort execution |

## Verification
Two functions can collide in one cycle. The first is the host's cancel, which is only valid while the engine runs. The second is the engine's completion, which closes that window. The bench writes cancel in the same cycle that `exec_done` is asserted. It then judges the outcome from the ports: the controller must be in COMPLETE with the new response length, and `exec_abort` must stay low. A second, smaller overlap is also exercised: a FIFO read and a retry write compete for the response pointer.

// File: rtl/cmdstat_pkg.sv
package cmdstat_pkg;

    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_RECEIVE = 2'd1,
        ST_EXECUTE = 2'd2,
        ST_COMPLETE = 2'd3
    } cs_state_e;

    // status byte bit positions (host-visible encoding)
    localparam int B_VALID  = 7;
    localparam int B_READY  = 6;
    localparam int B_GO     = 5;
    localparam int B_AVAIL  = 4;
    localparam int B_EXPECT = 3;
    localparam int B_RETRY  = 1;

    // extended status bit positions
    localparam int X_CANCEL = 0;
    localparam int X_FAM_LO = 2;

    // header layout: length occupies byte indices 2..5, big-endian
    localparam int HDR_LEN_FIRST = 2;
    localparam int HDR_LEN_LAST  = 5;
    localparam int HDR_MIN       = 6;

endpackage

// File: rtl/cmdstat_rx_len.sv
module cmdstat_rx_len
    import cmdstat_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             byte_we,
    input  logic [7:0]       byte_in,
    output logic             len_known,
    output logic             rx_full,
    output logic [CNT_W-1:0] remain
);
    localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);
    localparam logic [31:0] MIN_LEN = 32'(HDR_MIN);

    logic [CNT_W-1:0] rx_count;
    logic [31:0]      hdr_len;
    logic [31:0]      cnt32;
    logic [31:0]      target;
    logic [31:0]      rem32;
    logic             take;

    assign cnt32     = 32'(rx_count);
    assign len_known = cnt32 >= MIN_LEN;
    assign target    = (hdr_len > MIN_LEN) ? hdr_len : MIN_LEN;
    assign rx_full   = len_known && (cnt32 >= target);
    assign rem32     = rx_full ? 32'd0 : (target - cnt32);
    assign remain    = (rem32 > CNT_MAX) ? '1 : rem32[CNT_W-1:0];
    assign take      = byte_we && !rx_full && (rx_count != '1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rx_count <= '0;
            hdr_len  <= '0;
        end else if (take) begin
            rx_count <= rx_count + 1'b1;
            if (cnt32 >= 32'(HDR_LEN_FIRST) && cnt32 <= 32'(HDR_LEN_LAST))
                hdr_len <= {hdr_len[23:0], byte_in};
        end
    end

endmodule

// File: rtl/cmdstat_rsp_ptr.sv
module cmdstat_rsp_ptr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             rewind,
    input  logic             adv,
    output logic [CNT_W-1:0] ptr,
    output logic             avail,
    output logic [CNT_W-1:0] remain
);
    logic [CNT_W-1:0] rsp_len;

    assign avail  = ptr < rsp_len;
    assign remain = avail ? (rsp_len - ptr) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_len <= '0;
            ptr     <= '0;
        end else if (load) begin
            rsp_len <= load_len;
            ptr     <= '0;
        end else if (rewind) begin
            ptr <= '0;
        end else if (adv && avail) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/cmdstat_burst_cap.sv
module cmdstat_burst_cap
    import cmdstat_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BURST_MAX = 32
) (
    input  cs_state_e        state,
    input  logic             rx_known,
    input  logic             rx_full,
    input  logic [CNT_W-1:0] rx_remain,
    input  logic [CNT_W-1:0] rsp_remain,
    output logic [CNT_W-1:0] burst
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(BURST_MAX);

    always_comb begin
        burst = '0;
        unique case (state)
            ST_READY:    burst = CAP;
            ST_RECEIVE: begin
                if (rx_full)        burst = '0;
                else if (!rx_known) burst = CAP;
                else                burst = (rx_remain < CAP) ? rx_remain : CAP;
            end
            ST_EXECUTE:  burst = '0;
            ST_COMPLETE: burst = (rsp_remain < CAP) ? rsp_remain : CAP;
            default:     burst = '0;
        endcase
    end

endmodule

// File: rtl/cmdstat_ctrl.sv
module cmdstat_ctrl
    import cmdstat_pkg::*;
#(
    parameter int         CNT_W     = 16,
    parameter int         BURST_MAX = 32,
    parameter logic [1:0] FAMILY    = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sts_wr,
    input  logic [7:0]       sts_wdata,
    input  logic             stx_wr,
    input  logic [7:0]       stx_wdata,
    input  logic             fifo_wr,
    input  logic [7:0]       fifo_wdata,
    input  logic             fifo_rd,
    input  logic             exec_done,
    input  logic [CNT_W-1:0] exec_rsp_len,
    output logic [7:0]       sts_rdata,
    output logic [7:0]       stx_rdata,
    output logic [CNT_W-1:0] burst_cnt,
    output logic [CNT_W-1:0] rsp_ptr,
    output logic             exec_start,
    output logic             exec_abort
);
    cs_state_e state, state_nxt;

    logic go_req, retry_req, ready_req, cancel_req;
    logic go_acc, done_acc, cancel_acc, discard;
    logic rx_we, rx_known, rx_full;
    logic [CNT_W-1:0] rx_remain, rsp_remain;
    logic rsp_avail;
    logic start_q, abort_q;
    logic unused_wbits;

    assign unused_wbits = ^{sts_wdata[7], sts_wdata[4:2], sts_wdata[0], stx_wdata[7:1]};

    assign go_req     = sts_wr && sts_wdata[B_GO];
    assign retry_req  = sts_wr && sts_wdata[B_RETRY];
    assign ready_req  = sts_wr && sts_wdata[B_READY];
    assign cancel_req = stx_wr && stx_wdata[X_CANCEL];

    assign go_acc     = (state == ST_RECEIVE) && rx_full && go_req;
    assign done_acc   = (state == ST_EXECUTE) && exec_done;
    assign cancel_acc = (state == ST_EXECUTE) && cancel_req && !exec_done;
    assign discard    = (state == ST_COMPLETE) && ready_req;
    assign rx_we      = fifo_wr && ((state == ST_READY) || (state == ST_RECEIVE));

    cmdstat_rx_len #(.CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (discard),
        .byte_we   (rx_we),
        .byte_in   (fifo_wdata),
        .len_known (rx_known),
        .rx_full   (rx_full),
        .remain    (rx_remain)
    );

    cmdstat_rsp_ptr #(.CNT_W(CNT_W)) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (done_acc),
        .load_len (exec_rsp_len),
        .rewind   ((state == ST_COMPLETE) && retry_req),
        .adv      ((state == ST_COMPLETE) && fifo_rd),
        .ptr      (rsp_ptr),
        .avail    (rsp_avail),
        .remain   (rsp_remain)
    );

    cmdstat_burst_cap #(.CNT_W(CNT_W), .BURST_MAX(BURST_MAX)) u_burst (
        .state      (state),
        .rx_known   (rx_known),
        .rx_full    (rx_full),
        .rx_remain  (rx_remain),
        .rsp_remain (rsp_remain),
        .burst      (burst_cnt)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_READY:    if (rx_we)    state_nxt = ST_RECEIVE;  // first_byte
            ST_RECEIVE:  if (go_acc)   state_nxt = ST_EXECUTE;  // go_accept
            ST_EXECUTE:  if (done_acc) state_nxt = ST_COMPLETE; // exec_finish
            ST_COMPLETE: if (discard)  state_nxt = ST_READY;    // discard
            default:                   state_nxt = ST_READY;
        endcase
    end

    // state register and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_READY;
            start_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state   <= state_nxt;
            start_q <= go_acc;
            abort_q <= cancel_acc;
        end
    end

    // outputs
    always_comb begin
        sts_rdata = 8'h00;
        stx_rdata = 8'h00;
        stx_rdata[X_FAM_LO +: 2] = FAMILY;
        unique case (state)
            ST_READY: begin
                sts_rdata[B_VALID] = 1'b1;
                sts_rdata[B_READY] = 1'b1;
            end
            ST_RECEIVE: begin
                sts_rdata[B_VALID]  = 1'b1;
                sts_rdata[B_EXPECT] = !rx_full;
            end
            ST_EXECUTE: sts_rdata = 8'h00;
            ST_COMPLETE: begin
                sts_rdata[B_VALID] = 1'b1;
                sts_rdata[B_AVAIL] = rsp_avail;
            end
            default: sts_rdata = 8'h00;
        endcase
        exec_start = start_q;
        exec_abort = abort_q;
    end

endmodule

// File: rtl/cmdstat_ctrl_chk.sv
module cmdstat_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sts_wr,
    input logic [7:0]       sts_wdata,
    input logic             stx_wr,
    input logic [7:0]       stx_wdata,
    input logic             fifo_rd,
    input logic             exec_done,
    input logic [7:0]       sts_rdata,
    input logic [CNT_W-1:0] burst_cnt,
    input logic [CNT_W-1:0] rsp_ptr,
    input logic             exec_start,
    input logic             exec_abort
);
    AST_START_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> (sts_rdata == 8'h00)); // R4

    AST_START_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> $past(sts_wr && sts_wdata[5])); // R4

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sts_rdata[6], sts_rdata[4], sts_rdata[3]})); // R2

    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_abort |-> $past(stx_wr && stx_wdata[0] && !exec_done)); // R9

    AST_AVAIL_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rdata[4] |-> (burst_cnt != '0)); // R6

    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && sts_rdata[4] && !sts_wr) |=> (rsp_ptr == CNT_W'($past(rsp_ptr) + 1'b1))); // R6

    AST_RETRY_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && sts_wdata[1] && !sts_wdata[6] && sts_rdata[4]) |=> (rsp_ptr == '0)); // R7
endmodule

bind cmdstat_ctrl cmdstat_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sts_wr     (sts_wr),
    .sts_wdata  (sts_wdata),
    .stx_wr     (stx_wr),
    .stx_wdata  (stx_wdata),
    .fifo_rd    (fifo_rd),
    .exec_done  (exec_done),
    .sts_rdata  (sts_rdata),
    .burst_cnt  (burst_cnt),
    .rsp_ptr    (rsp_ptr),
    .exec_start (exec_start),
    .exec_abort (exec_abort)
);

// File: tb/sim_cmdstat_ctrl.sv
module sim_cmdstat_ctrl;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sts_wr = 1'b0;
    logic [7:0]       sts_wdata = '0;
    logic             stx_wr = 1'b0;
    logic [7:0]       stx_wdata = '0;
    logic             fifo_wr = 1'b0;
    logic [7:0]       fifo_wdata = '0;
    logic             fifo_rd = 1'b0;
    logic             exec_done = 1'b0;
    logic [CNT_W-1:0] exec_rsp_len = '0;
    logic [7:0]       sts_rdata, stx_rdata;
    logic [CNT_W-1:0] burst_cnt, rsp_ptr;
    logic             exec_start, exec_abort;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cmdstat_ctrl u0 (.*);

    typedef struct {
        string       tag;
        logic [7:0]  sts;
        logic [15:0] burst;
        logic        start;
        logic        abort;
        logic [15:0] ptr;   // FFFF = not compared
    } exp_t;

    exp_t sb[$];

    // pending stimulus for the next cycle
    logic p_swr, p_xwr, p_fwr, p_frd, p_done;
    logic [7:0] p_swd, p_xwd, p_fwd;
    logic [15:0] p_rl;

    task automatic clr_pending();
        p_swr = 0; p_xwr = 0; p_fwr = 0; p_frd = 0; p_done = 0;
        p_swd = 0; p_xwd = 0; p_fwd = 0; p_rl = 0;
    endtask

    task automatic cyc(input string tag, input logic [7:0] e_sts, input logic [15:0] e_burst,
                       input logic e_start, input logic e_abort, input logic [15:0] e_ptr);
        exp_t it;
        @(negedge clk);
        sts_wr = p_swr; sts_wdata = p_swd;
        stx_wr = p_xwr; stx_wdata = p_xwd;
        fifo_wr = p_fwr; fifo_wdata = p_fwd;
        fifo_rd = p_frd; exec_done = p_done; exec_rsp_len = p_rl;
        it.tag = tag; it.sts = e_sts; it.burst = e_burst;
        it.start = e_start; it.abort = e_abort; it.ptr = e_ptr;
        sb.push_back(it);
        clr_pending();
    endtask

    task automatic wbyte(input string tag, input logic [7:0] b, input logic [7:0] e_sts,
                         input logic [15:0] e_burst);
        p_fwr = 1; p_fwd = b;
        cyc(tag, e_sts, e_burst, 0, 0, 16'hFFFF);
    endtask

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // monitor: compare one expected item per cycle after the edge
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                chk({it.tag, " status"}, 16'(sts_rdata), 16'(it.sts));
                chk({it.tag, " burst"}, burst_cnt, it.burst);
                chk({it.tag, " exec_start"}, 16'(exec_start), 16'(it.start));
                chk({it.tag, " exec_abort"}, 16'(exec_abort), 16'(it.abort));
                chk({it.tag, " R11 ext status"}, 16'(stx_rdata), 16'h0004);
                if (it.ptr != 16'hFFFF)
                    chk({it.tag, " rsp_ptr"}, rsp_ptr, it.ptr);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clr_pending();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc("R1 reset", 8'hC0, 32, 0, 0, 0);

        // command A: length 10
        wbyte("R2 first byte", 8'h80, 8'h88, 32);
        wbyte("R3 b1", 8'h01, 8'h88, 32);
        wbyte("R3 b2", 8'h00, 8'h88, 32);
        p_swr = 1; p_swd = 8'h20;
        cyc("R4 go while expecting", 8'h88, 32, 0, 0, 16'hFFFF);
        wbyte("R3 b3", 8'h00, 8'h88, 32);
        wbyte("R3 b4", 8'h00, 8'h88, 32);
        wbyte("R3 b5 length known", 8'h0A, 8'h88, 4);
        p_swr = 1; p_swd = 8'h40;
        cyc("R10 ready in receive", 8'h88, 4, 0, 0, 16'hFFFF);
        wbyte("R3 b6", 8'h11, 8'h88, 3);
        wbyte("R3 b7", 8'h22, 8'h88, 2);
        wbyte("R3 b8", 8'h33, 8'h88, 1);
        wbyte("R3 b9 last", 8'h44, 8'h80, 0);
        wbyte("R3 extra byte", 8'h55, 8'h80, 0);
        p_swr = 1; p_swd = 8'h20;
        cyc("R4 go accepted", 8'h00, 0, 1, 0, 16'hFFFF);
        cyc("R4 start one cycle", 8'h00, 0, 0, 0, 16'hFFFF);
        p_swr = 1; p_swd = 8'h02;
        cyc("R7 retry in execute", 8'h00, 0, 0, 0, 16'hFFFF);
        p_xwr = 1; p_xwd = 8'h01;
        cyc("R8 cancel in execute", 8'h00, 0, 0, 1, 16'hFFFF);
        cyc("R8 abort one cycle", 8'h00, 0, 0, 0, 16'hFFFF);
        p_done = 1; p_rl = 3;
        cyc("R5 done len 3", 8'h90, 3, 0, 0, 0);
        p_frd = 1; cyc("R6 read 1", 8'h90, 2, 0, 0, 1);
        p_frd = 1; cyc("R6 read 2", 8'h90, 1, 0, 0, 2);
        p_swr = 1; p_swd = 8'h02; p_frd = 1;
        cyc("R7 retry beats read", 8'h90, 3, 0, 0, 0);
        p_frd = 1; cyc("R6 reread 1", 8'h90, 2, 0, 0, 1);
        p_frd = 1; cyc("R6 reread 2", 8'h90, 1, 0, 0, 2);
        p_frd = 1; cyc("R6 drained", 8'h80, 0, 0, 0, 3);
        p_frd = 1; cyc("R6 read past end", 8'h80, 0, 0, 0, 3);
        p_xwr = 1; p_xwd = 8'h01;
        cyc("R8 cancel in complete", 8'h80, 0, 0, 0, 3);
        p_swr = 1; p_swd = 8'h40;
        cyc("R10 discard", 8'hC0, 32, 0, 0, 16'hFFFF);

        // command B: header length 2, minimum 6 bytes
        wbyte("R2 B first", 8'h80, 8'h88, 32);
        wbyte("R3 B b1", 8'h01, 8'h88, 32);
        wbyte("R3 B b2", 8'h00, 8'h88, 32);
        wbyte("R3 B b3", 8'h00, 8'h88, 32);
        wbyte("R3 B b4", 8'h00, 8'h88, 32);
        wbyte("R3 B short length", 8'h02, 8'h80, 0);
        p_swr = 1; p_swd = 8'h20;
        cyc("R4 B go", 8'h00, 0, 1, 0, 16'hFFFF);
        p_done = 1; p_rl = 40; p_xwr = 1; p_xwd = 8'h01;
        cyc("R9 cancel with done", 8'h90, 32, 0, 0, 0);
        cyc("R9 no late abort", 8'h90, 32, 0, 0, 0);
        p_frd = 1; cyc("R6 burst capped", 8'h90, 32, 0, 0, 1);
        p_swr = 1; p_swd = 8'h40;
        cyc("R10 discard pending", 8'hC0, 32, 0, 0, 16'hFFFF);

        // command C: empty response
        wbyte("R2 C first", 8'h80, 8'h88, 32);
        for (int i = 1; i < 5; i++) wbyte("R3 C hdr", (i == 1) ? 8'h01 : 8'h00, 8'h88, 32);
        wbyte("R3 C last", 8'h06, 8'h80, 0);
        p_swr = 1; p_swd = 8'h20;
        cyc("R4 C go", 8'h00, 0, 1, 0, 16'hFFFF);
        p_done = 1; p_rl = 0;
        cyc("R5 empty response", 8'h80, 0, 0, 0, 0);
        p_swr = 1; p_swd = 8'h40;
        cyc("R10 C discard", 8'hC0, 32, 0, 0, 16'hFFFF);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule